// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns a fast input clock into a single-cycle tick. A serial receiver and transmitter use the tick as a clock enable at sixteen times the serial bit rate. One 32-bit control word sets the tick rate. It holds a 12-bit divisor field, a bit that selects an extra divide-by-16 stage for slow rates, and a run-enable bit. The divisor field holds the wanted division minus one, so the counter divides by any value from 1 to 4096. With the extra stage selected, the division becomes 16 × (field + 1).

Software writes the control word through a single-cycle write strobe and can read it back. Starting the generator clears its internal state, so the first tick is exactly one full period away. A divisor written while the generator runs waits for the current period to end, so a period is never cut short.

Top module: `baud_tick_gen`

## Requirements
- R1: After a synchronous reset, the control readback is 0 and `tick` is low.
- R2: The control word places the prescaler select at bit 0, the divisor field (division minus one) at bits 12 down to 1, and the enable at bit 16. All other bits are dropped on write and read back as 0.
- R3: While enable is clear, `tick` stays low. A write that clears enable also suppresses any tick from that same clock edge onward.
- R4: With prescaler select clear, `tick` pulses high for exactly one cycle every field+1 cycles.
- R5: With prescaler select set, the spacing between ticks is 16 × (field+1) cycles.
- R6: A write that sets enable while it was clear starts a fresh period. The first tick appears exactly one period after the clock edge that accepted the write.
- R7: A field of 0 gives a tick on every cycle with the prescaler off, and on every 16th cycle with it on.
- R8: A new divisor or prescaler select written while running takes effect only after the next tick. The period already in progress keeps its old length.
- R9: Writing the control word again with enable still set does not restart the period.
- R10: The largest field, 4095, gives a tick spacing of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Control word readback |
| tick | output | 1 | Single-cycle baud tick |

## Verification
The bench builds the block with its default parameters: a 12-bit divisor counter and a 16-step prescaler. With these values the full 4096-cycle span of the counter fits in one directed run, and several prescaled periods fit in the random phase. Random divisors are kept mostly small, so many reloads and mid-period divisor changes happen within the cycle budget. Directed cases cover field 0 in both prescaler modes, restart through enable, and disabling in the same cycle that a tick is due.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int REG_W    = 32;
    localparam int CNT_W    = 12;
    localparam int PRE_DIV  = 16;
    localparam int PSEL_BIT = 0;
    localparam int DIV_LSB  = 1;
    localparam int EN_BIT   = 16;

    typedef struct packed {
        logic             en;
        logic             psel;
        logic [CNT_W-1:0] div;
    } baud_cfg_t;

    function automatic baud_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        baud_cfg_t c;
        c.en   = w[EN_BIT];
        c.psel = w[PSEL_BIT];
        c.div  = w[DIV_LSB +: CNT_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input baud_cfg_t c);
        logic [REG_W-1:0] w;
        w                  = '0;
        w[EN_BIT]          = c.en;
        w[PSEL_BIT]        = c.psel;
        w[DIV_LSB +: CNT_W] = c.div;
        return w;
    endfunction

endpackage

// File: rtl/baud_ctrl_reg.sv
module baud_ctrl_reg
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output baud_cfg_t        cfg_q,
    output baud_cfg_t        cfg_w,
    output logic             start,
    output logic             run,
    output logic [REG_W-1:0] rdata
);

    logic en_next;

    assign cfg_w   = unpack_cfg(wdata);
    assign en_next = we ? cfg_w.en : cfg_q.en;
    assign start   = en_next & ~cfg_q.en;
    assign run     = en_next & cfg_q.en;
    assign rdata   = pack_cfg(cfg_q);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (we)
            cfg_q <= cfg_w;
    end

    AST_START_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        start |-> we) else $error("start without write");                         // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> rdata == pack_cfg($past(cfg_w))) else $error("write lost");          // R2

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int PRE_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_psel,
    input  logic run,
    input  logic reload,
    input  logic reload_psel,
    output logic step
);

    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             act_psel;

    assign step = run & (~act_psel | (pre_q == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q    <= PRE_MAX;
            act_psel <= 1'b0;
        end else if (start) begin
            pre_q    <= PRE_MAX;
            act_psel <= start_psel;
        end else if (run) begin
            if (act_psel)
                pre_q <= (pre_q == '0) ? PRE_MAX : pre_q - 1'b1;
            if (reload)
                act_psel <= reload_psel;
        end
    end

    AST_PRE_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (step && act_psel) |=> pre_q == PRE_MAX) else $error("prescaler wrap"); // R5

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        start |=> pre_q == PRE_MAX) else $error("prescaler not cleared");    // R6

endmodule

// File: rtl/baud_divcounter.sv
module baud_divcounter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_div,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] reload_div,
    output logic             at_zero,
    output logic             tick_q
);

    logic [CNT_W-1:0] cnt_q;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= start_div;
            tick_q <= 1'b0;
        end else begin
            tick_q <= run & step & at_zero;
            if (run && step)
                cnt_q <= at_zero ? reload_div : cnt_q - 1'b1;
        end
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start |=> cnt_q == $past(start_div)) else $error("start load");        // R6

    AST_SINGLE_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick_q && !at_zero) |=> !tick_q) else $error("tick too wide");       // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(cnt_q)) else $error("counter moved");    // R3

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int PRE_STEPS = PRE_DIV
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        tick
);

    baud_cfg_t cfg_q;
    baud_cfg_t cfg_w;
    logic      start;
    logic      run;
    logic      step;
    logic      at_zero;
    logic      reload;

    assign reload = step & at_zero;

    baud_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q),
        .cfg_w (cfg_w),
        .start (start),
        .run   (run),
        .rdata (cfg_rdata)
    );

    baud_prescaler #(.PRE_DIV(PRE_STEPS)) u_pre (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_psel  (cfg_w.psel),
        .run         (run),
        .reload      (reload),
        .reload_psel (cfg_q.psel),
        .step        (step)
    );

    baud_divcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_div  (cfg_w.div),
        .run        (run),
        .step       (step),
        .reload_div (cfg_q.div),
        .at_zero    (at_zero),
        .tick_q     (tick)
    );

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        tick |-> cfg_rdata[EN_BIT]) else $error("tick while disabled");        // R3

    AST_NO_TICK_ON_START: assert property (@(posedge clk) disable iff (rst)
        start |=> !tick) else $error("tick at start");                         // R6

endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] WMASK = 32'h0001_1FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";

    logic [31:0] m_reg = '0;
    longint      edge_n = 0;
    longint      next_t = 0;
    bit          exp_tick = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tick      (tick)
    );

    function automatic longint period_of(input logic [31:0] w);
        longint d = longint'(w[12:1]) + 1;
        return w[0] ? 16 * d : d;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h at edge %0d",
                     req, what, act, exp, edge_n);
        end
    endtask

    task automatic cycle(input bit we, input logic [31:0] d);
        logic [31:0] old;
        @(negedge clk);
        cfg_we    = we;
        cfg_wdata = d;
        @(posedge clk);
        edge_n++;
        old = m_reg;
        if (we) m_reg = d & WMASK;
        exp_tick = 0;
        if (!m_reg[16]) begin
            next_t = 0;
        end else if (!old[16]) begin
            next_t = edge_n + period_of(m_reg);
        end else if (edge_n == next_t) begin
            exp_tick = 1;
            next_t = edge_n + period_of(old);
        end
        #1;
        check(cur_req, "tick", {31'd0, tick}, {31'd0, exp_tick});
        check(cur_req, "readback", cfg_rdata, m_reg);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, '0);
    endtask

    function automatic logic [31:0] mk(input bit en, input bit ps, input int div);
        return {15'd0, en, 3'd0, div[11:0], ps};
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired at edge %0d", edge_n);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        cur_req = "R1";
        check("R1", "reset readback", cfg_rdata, 32'h0);
        check("R1", "reset tick", {31'd0, tick}, 32'h0);

        cur_req = "R2";
        cycle(1'b1, 32'hFFFE_FFFF);
        idle(10);
        cycle(1'b1, 32'h0);

        cur_req = "R4";
        cycle(1'b1, mk(1, 0, 4));
        idle(30);

        cur_req = "R9";
        for (int k = 0; k < 6; k++) begin
            cycle(1'b1, mk(1, 0, 4));
            idle(2);
        end

        cur_req = "R3";
        cycle(1'b1, mk(0, 0, 4));
        idle(20);

        cur_req = "R6";
        cycle(1'b1, mk(1, 0, 6));
        idle(20);
        cycle(1'b1, mk(0, 0, 6));
        cycle(1'b1, mk(1, 0, 6));
        idle(20);

        cur_req = "R7";
        cycle(1'b1, mk(0, 0, 0));
        cycle(1'b1, mk(1, 0, 0));
        idle(10);
        cycle(1'b1, mk(0, 1, 0));
        cycle(1'b1, mk(1, 1, 0));
        idle(60);

        cur_req = "R5";
        cycle(1'b1, mk(0, 1, 2));
        cycle(1'b1, mk(1, 1, 2));
        idle(150);

        cur_req = "R8";
        cycle(1'b1, mk(1, 0, 9));
        idle(12);
        cycle(1'b1, mk(1, 0, 1));
        idle(20);
        cycle(1'b1, mk(1, 1, 1));
        idle(80);
        cycle(1'b1, mk(1, 0, 3));
        idle(60);

        cur_req = "R3";
        while (next_t != edge_n + 1) idle(1);
        cycle(1'b1, mk(0, 0, 3));
        idle(15);

        cur_req = "R10";
        cycle(1'b1, mk(1, 0, 4095));
        idle(8300);
        cycle(1'b1, mk(0, 0, 0));

        cur_req = "R8";
        for (int r = 0; r < 60; r++) begin
            bit en = ($urandom % 8) != 0;
            bit ps = ($urandom % 4) == 0;
            int dv = ($urandom % 5 == 0) ? int'($urandom % 4096) % 64
                                         : int'($urandom % 12);
            cycle(1'b1, mk(en, ps, dv) | ($urandom & 32'hFFFE_E000));
            idle(int'($urandom % 300));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule